// File: doc/BRIEF.md
# Inter-CPU Byte Mailbox

This block passes single bytes between a 16-bit main processor and an 8-bit sound processor. The main processor writes a command byte using even-address byte cycles, so only the upper lane (bits 15..8) of its data bus carries the byte. The mailbox holds that byte and signals the capture toward an interrupt controller. The sound processor reads the byte with its own read strobe. It can also leave a reply byte in a second register, which the main processor reads back on the same upper lane.

Both processors' strobes arrive without a fixed timing relation to the system clock. Each strobe passes through a synchroniser chain of `SYNC_STAGES` flops. A write is captured once, on the rising edge of its synchronised strobe, and the data must be held steady while the strobe is high. A capture does three things: it stores the byte, produces a one-cycle notification pulse and sets a pending flag. The interrupt request is the pending flag gated by an enable input. A synchronous clear input empties the command byte and drops the pending flag.

Top module: `ipc_mailbox`

## Requirements
- R1: While reset is high and in the cycle after its release, the command and reply bytes are 0x00, the notification pulse and interrupt request are low, and both output enables are low.
- R2: A main-side write strobe captures `host_wdata` into the command byte at the clock edge SYNC_STAGES+1 edges after the strobe is first sampled high.
- R3: Each capture raises `cmd_written` for exactly one clock cycle, in the cycle the new byte becomes visible, and sets the pending flag.
- R4: `irq_out` is high exactly when the pending flag is set and `irq_enable` is high. A capture made while the enable is low stays pending and appears as soon as the enable rises.
- R5: `clear` high at a clock edge sets the command byte to 0x00 and drops the pending flag. It takes priority over a capture at the same edge, which is then lost and produces no pulse.
- R6: A new main-side write overwrites a byte that has not been read and raises the notification pulse again.
- R7: While the synchronised sound read strobe is high, `snd_oe` is high and `snd_rdata` equals the command byte. Otherwise `snd_oe` is low and `snd_rdata` is 0x00.
- R8: A sound-side write captures `snd_wdata` into the reply byte. While the synchronised main read strobe is high, `host_oe` is high and `host_rdata` equals the reply byte. Otherwise both are low or zero.
- R9: A write strobe held high captures once. Changing the data while the strobe stays high alters neither the stored byte nor the pulse count.
- R10: A sound-side read leaves the command byte and the pending flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Main-side write strobe for the command byte, active high, asynchronous |
| host_rd | input | 1 | Main-side read strobe for the reply byte, active high, asynchronous |
| host_wdata | input | 8 | Main data bus bits 15..8 (write) |
| host_rdata | output | 8 | Main data bus bits 15..8 (read), reply byte |
| host_oe | output | 1 | Drive enable for `host_rdata` |
| snd_wr | input | 1 | Sound-side write strobe for the reply byte, active high, asynchronous |
| snd_rd | input | 1 | Sound-side read strobe for the command byte, active high, asynchronous |
| snd_wdata | input | 8 | Sound data bus (write) |
| snd_rdata | output | 8 | Sound data bus (read), command byte |
| snd_oe | output | 1 | Drive enable for `snd_rdata` |
| clear | input | 1 | Synchronous clear of command byte and pending flag |
| irq_enable | input | 1 | Gate for the interrupt request |
| cmd_written | output | 1 | One-cycle pulse on each command capture |
| irq_out | output | 1 | Interrupt request: pending flag and enable |

## Verification
The bench builds the mailbox with `SYNC_STAGES` set to 3 instead of the default 2. Every expected cycle in the bench is derived from that parameter, so a latency fixed at the default depth would show up as a timing mismatch. With the deeper chain, a held strobe spends several cycles fully synchronised. This gives the changing data in the held-strobe case room to show up if a second capture occurred. A longer chain also gives a wide window for holding `clear` across the capture edge.

// File: rtl/ipc_mailbox_pkg.sv
package ipc_mailbox_pkg;

    localparam int MBX_BYTE_W = 8;

    typedef logic [MBX_BYTE_W-1:0] mbx_byte_t;

    // State of the main-to-sound command slot
    typedef struct packed {
        mbx_byte_t data;
        logic      pending;
        logic      written;
    } cmd_state_t;

    localparam mbx_byte_t MBX_EMPTY = '0;

    // Value placed on a bus lane: data when enabled, zero otherwise
    function automatic mbx_byte_t lane_value(input logic en, input mbx_byte_t d);
        return en ? d : MBX_EMPTY;
    endfunction

endpackage

// File: rtl/mbx_strobe_sync.sv
module mbx_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic level
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= async_in;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], async_in};
            end
        end
    endgenerate

    assign level = chain_q[STAGES-1];
endmodule

// File: rtl/mbx_edge_det.sv
module mbx_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic rise
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= level;
    end

    assign rise = level & ~prev_q;
endmodule

// File: rtl/mbx_cmd_reg.sv
module mbx_cmd_reg
    import ipc_mailbox_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       capture,
    input  mbx_byte_t  din,
    output cmd_state_t state
);
    cmd_state_t state_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            state_q.data    <= MBX_EMPTY;
            state_q.pending <= 1'b0;
            state_q.written <= 1'b0;
        end else if (capture) begin
            state_q.data    <= din;
            state_q.pending <= 1'b1;
            state_q.written <= 1'b1;
        end else begin
            state_q.written <= 1'b0;
        end
    end

    assign state = state_q;
endmodule

// File: rtl/mbx_reply_reg.sv
module mbx_reply_reg
    import ipc_mailbox_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      capture,
    input  mbx_byte_t din,
    output mbx_byte_t dout
);
    mbx_byte_t data_q;

    always_ff @(posedge clk) begin
        if (rst)          data_q <= MBX_EMPTY;
        else if (capture) data_q <= din;
    end

    assign dout = data_q;
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
    import ipc_mailbox_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  host_wr,
    input  logic                  host_rd,
    input  logic [MBX_BYTE_W-1:0] host_wdata,
    output logic [MBX_BYTE_W-1:0] host_rdata,
    output logic                  host_oe,
    input  logic                  snd_wr,
    input  logic                  snd_rd,
    input  logic [MBX_BYTE_W-1:0] snd_wdata,
    output logic [MBX_BYTE_W-1:0] snd_rdata,
    output logic                  snd_oe,
    input  logic                  clear,
    input  logic                  irq_enable,
    output logic                  cmd_written,
    output logic                  irq_out
);
    // Strobe order inside the synchroniser bank
    localparam int IDX_HWR = 0;
    localparam int IDX_HRD = 1;
    localparam int IDX_SWR = 2;
    localparam int IDX_SRD = 3;
    localparam int N_STB   = 4;

    logic [N_STB-1:0] stb_raw;
    logic [N_STB-1:0] stb_sync;
    logic             host_cap;
    logic             snd_cap;
    cmd_state_t       cmd_state;
    mbx_byte_t        cmd_q;
    logic             pending_q;
    mbx_byte_t        reply_q;

    assign stb_raw[IDX_HWR] = host_wr;
    assign stb_raw[IDX_HRD] = host_rd;
    assign stb_raw[IDX_SWR] = snd_wr;
    assign stb_raw[IDX_SRD] = snd_rd;

    generate
        for (genvar i = 0; i < N_STB; i++) begin : g_sync
            mbx_strobe_sync #(.STAGES(SYNC_STAGES)) i_sync (
                .clk      (clk),
                .rst      (rst),
                .async_in (stb_raw[i]),
                .level    (stb_sync[i])
            );
        end
    endgenerate

    mbx_edge_det i_host_edge (
        .clk   (clk),
        .rst   (rst),
        .level (stb_sync[IDX_HWR]),
        .rise  (host_cap)
    );

    mbx_edge_det i_snd_edge (
        .clk   (clk),
        .rst   (rst),
        .level (stb_sync[IDX_SWR]),
        .rise  (snd_cap)
    );

    mbx_cmd_reg i_cmd (
        .clk     (clk),
        .rst     (rst),
        .clear   (clear),
        .capture (host_cap),
        .din     (host_wdata),
        .state   (cmd_state)
    );

    mbx_reply_reg i_reply (
        .clk     (clk),
        .rst     (rst),
        .capture (snd_cap),
        .din     (snd_wdata),
        .dout    (reply_q)
    );

    assign cmd_q       = cmd_state.data;
    assign pending_q   = cmd_state.pending;
    assign cmd_written = cmd_state.written;
    assign irq_out     = pending_q & irq_enable;

    assign snd_oe     = stb_sync[IDX_SRD];
    assign snd_rdata  = lane_value(snd_oe, cmd_q);
    assign host_oe    = stb_sync[IDX_HRD];
    assign host_rdata = lane_value(host_oe, reply_q);
endmodule

// File: rtl/ipc_mailbox_chk.sv
module ipc_mailbox_chk
    import ipc_mailbox_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      clear,
    input logic      irq_enable,
    input logic      irq_out,
    input logic      cmd_written,
    input logic      snd_oe,
    input mbx_byte_t snd_rdata,
    input mbx_byte_t cmd_q,
    input logic      pending_q
);
    // R3
    pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_written |=> !cmd_written);

    // R3
    pulse_sets_pending_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_written |-> pending_q);

    // R4
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !irq_enable |-> !irq_out);

    // R5
    clear_empties_chk: assert property (@(posedge clk) disable iff (rst)
        clear |=> (cmd_q == MBX_EMPTY && !pending_q && !cmd_written));

    // R6
    cmd_change_cause_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(cmd_q) |-> (cmd_written || $past(clear)));

    // R7
    snd_drive_chk: assert property (@(posedge clk) disable iff (rst)
        snd_oe |-> snd_rdata == cmd_q);

    // R7
    snd_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !snd_oe |-> snd_rdata == MBX_EMPTY);

    // R10
    pending_drop_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(pending_q) |-> $past(clear));
endmodule

bind ipc_mailbox ipc_mailbox_chk i_chk (
    .clk         (clk),
    .rst         (rst),
    .clear       (clear),
    .irq_enable  (irq_enable),
    .irq_out     (irq_out),
    .cmd_written (cmd_written),
    .snd_oe      (snd_oe),
    .snd_rdata   (snd_rdata),
    .cmd_q       (cmd_q),
    .pending_q   (pending_q)
);

// File: tb/test_ipc_mailbox.sv
module test_ipc_mailbox;
    localparam int S = 3;
    localparam int L = S + 1;

    localparam int SEL_SRD  = 0;
    localparam int SEL_SOE  = 1;
    localparam int SEL_HRD  = 2;
    localparam int SEL_HOE  = 3;
    localparam int SEL_PUL  = 4;
    localparam int SEL_IRQ  = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       host_oe;
    logic       snd_wr = 1'b0, snd_rd = 1'b0;
    logic [7:0] snd_wdata = '0;
    logic [7:0] snd_rdata;
    logic       snd_oe;
    logic       clear = 1'b0;
    logic       irq_enable = 1'b0;
    logic       cmd_written;
    logic       irq_out;

    ipc_mailbox #(.SYNC_STAGES(S)) i_ipc_mailbox (
        .clk(clk), .rst(rst),
        .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_oe(host_oe),
        .snd_wr(snd_wr), .snd_rd(snd_rd), .snd_wdata(snd_wdata),
        .snd_rdata(snd_rdata), .snd_oe(snd_oe),
        .clear(clear), .irq_enable(irq_enable),
        .cmd_written(cmd_written), .irq_out(irq_out)
    );

    always #10 clk = ~clk;

    typedef struct {
        int         cyc;
        int         sel;
        logic [7:0] val;
        string      req;
    } item_t;

    item_t q[$];
    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    bit    finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] observe(input int sel);
        case (sel)
            SEL_SRD: return snd_rdata;
            SEL_SOE: return {7'd0, snd_oe};
            SEL_HRD: return host_rdata;
            SEL_HOE: return {7'd0, host_oe};
            SEL_PUL: return {7'd0, cmd_written};
            default: return {7'd0, irq_out};
        endcase
    endfunction

    // Monitor: compares queued expectations at the falling edge
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].cyc <= cyc) begin
            item_t it;
            logic [7:0] act;
            it  = q.pop_front();
            act = observe(it.sel);
            checks++;
            if (act !== it.val) begin
                errors++;
                $display("FAIL %s sel=%0d cycle=%0d actual=%02h expected=%02h",
                         it.req, it.sel, cyc, act, it.val);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic expect_at(input int d, input int sel, input logic [7:0] v, input string req);
        item_t it;
        it.cyc = cyc + d; it.sel = sel; it.val = v; it.req = req;
        q.push_back(it);
    endtask

    task automatic host_write(input logic [7:0] b, input logic pulse, input string req);
        host_wdata = b;
        host_wr = 1'b1;
        expect_at(S,     SEL_PUL, 8'd0, "R2");
        expect_at(L,     SEL_PUL, {7'd0, pulse}, req);
        expect_at(L + 1, SEL_PUL, 8'd0, "R3");
        tick(L + 2);
        host_wr = 1'b0;
        tick(S + 2);
    endtask

    task automatic snd_write(input logic [7:0] b);
        snd_wdata = b;
        snd_wr = 1'b1;
        tick(L + 1);
        snd_wr = 1'b0;
        tick(S + 2);
    endtask

    task automatic snd_read(input logic [7:0] v, input string req);
        snd_rd = 1'b1;
        expect_at(S - 1, SEL_SOE, 8'd0, "R7");
        expect_at(S,     SEL_SOE, 8'd1, "R7");
        expect_at(S,     SEL_SRD, v, req);
        tick(S + 1);
        snd_rd = 1'b0;
        expect_at(S, SEL_SOE, 8'd0, "R7");
        expect_at(S, SEL_SRD, 8'd0, "R7");
        tick(S + 1);
    endtask

    task automatic host_read(input logic [7:0] v);
        host_rd = 1'b1;
        expect_at(S, SEL_HOE, 8'd1, "R8");
        expect_at(S, SEL_HRD, v,    "R8");
        tick(S + 1);
        host_rd = 1'b0;
        expect_at(S, SEL_HOE, 8'd0, "R8");
        expect_at(S, SEL_HRD, 8'd0, "R8");
        tick(S + 1);
    endtask

    task automatic irq_is(input logic v, input string req);
        expect_at(0, SEL_IRQ, {7'd0, v}, req);
        tick(1);
    endtask

    initial begin
        tick(1);
        // R1: values during reset
        expect_at(0, SEL_SOE, 8'd0, "R1");
        expect_at(0, SEL_HOE, 8'd0, "R1");
        expect_at(0, SEL_PUL, 8'd0, "R1");
        tick(2);
        rst = 1'b0;
        tick(1);
        expect_at(0, SEL_IRQ, 8'd0, "R1");
        expect_at(0, SEL_SRD, 8'd0, "R1");
        expect_at(0, SEL_HRD, 8'd0, "R1");
        tick(1);
        snd_read(8'h00, "R1");
        host_read(8'h00);

        irq_enable = 1'b1;
        host_write(8'hA5, 1'b1, "R2");
        irq_is(1'b1, "R4");
        snd_read(8'hA5, "R7");
        irq_is(1'b1, "R10");
        snd_read(8'hA5, "R10");

        irq_enable = 1'b0;
        irq_is(1'b0, "R4");
        irq_enable = 1'b1;
        irq_is(1'b1, "R4");

        host_write(8'h5A, 1'b1, "R6");
        snd_read(8'h5A, "R6");

        clear = 1'b1;
        tick(1);
        clear = 1'b0;
        irq_is(1'b0, "R5");
        snd_read(8'h00, "R5");

        irq_enable = 1'b0;
        host_write(8'hC3, 1'b1, "R3");
        irq_is(1'b0, "R4");
        irq_enable = 1'b1;
        irq_is(1'b1, "R4");
        snd_read(8'hC3, "R4");

        // R5: clear held across the capture edge wins
        clear = 1'b1;
        host_write(8'h77, 1'b0, "R5");
        clear = 1'b0;
        irq_is(1'b0, "R5");
        snd_read(8'h00, "R5");

        // R9: held strobe with changing data captures once
        host_wdata = 8'h11;
        host_wr = 1'b1;
        expect_at(L,     SEL_PUL, 8'd1, "R9");
        expect_at(L + 1, SEL_PUL, 8'd0, "R9");
        tick(L + 1);
        host_wdata = 8'h22;
        for (int k = 1; k <= 4; k++) expect_at(k, SEL_PUL, 8'd0, "R9");
        tick(5);
        host_wr = 1'b0;
        tick(S + 2);
        snd_read(8'h11, "R9");

        snd_write(8'h96);
        host_read(8'h96);
        snd_write(8'h3E);
        host_read(8'h3E);

        while (q.size() != 0) tick(1);
        tick(1);
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule